// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Access Controller

This block connects a host request port to an external serial NOR flash over a four-wire serial link. A host read of one, two or four bytes becomes a single read sequence on the link. The request offset is the flash address itself, because the window starts at flash address zero. The host is held off, with ready low, until every byte has returned. A host byte write, a sector erase or a whole-device erase becomes a short chain of link frames. The chain is a write-enable frame, then the command frame, then repeated status reads until the flash reports it is no longer busy. A poll limit bounds that wait, and overrunning it leaves a sticky error flag.

Software may also take the flash pins for direct bit-level control. When it asks and the controller is idle, ownership is granted and the pins follow the software-driven inputs. A host request that arrives during that time waits. It is not dropped, and it runs once ownership is returned.

Top module: `sfc_mmio_ctrl`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, `req_ready`, `erase_done`, `bb_grant` and `timeout_err` are all low.
- R2: A read (`req_op` = 0) sends one frame: byte 0x03, then the 24-bit `req_addr` most significant byte first, with no offset added. Data leaves most significant bit first in SPI mode 0: the clock idles low, and the output bit changes only while the clock is low.
- R3: `req_size` 0 returns one byte, 1 returns two bytes, and 2 or 3 return four bytes. The byte from the lowest flash address lands in `req_rdata[7:0]`, and lanes that are not read are zero.
- R4: `req_ready` stays low while a request is in progress. It is high for exactly one cycle when the request ends, and `req_rdata` is valid in that cycle.
- R5: A byte write (`req_op` = 1) sends a lone 0x06 frame, then a five-byte frame of 0x02, the address and `req_wdata`. It then sends two-byte status frames starting with 0x05 until status bit 0 reads 0.
- R6: A sector erase (`req_op` = 2) sends 0x06, then 0x20 with the address whose low 12 bits are cleared (4 KB sector), then status polls. `erase_done` is high in the `req_ready` cycle.
- R7: A chip erase (`req_op` = 3) sends 0x06, then a one-byte 0xC7 frame, then status polls. `erase_done` is high in the `req_ready` cycle.
- R8: If status bit 0 is still 1 after `cfg_poll_limit`+1 polls, the request ends and `timeout_err` goes high. It stays high until reset.
- R9: `bb_req` raised while idle gives `bb_grant` on the next cycle. While granted, `spi_cs_n`, `spi_sck` and `spi_mosi` follow `bb_cs_n`, `bb_sck` and `bb_mosi`. A host request made during the grant does not start until the grant is released, and then it completes normally.
- R10: Each high phase and each low phase of the serial clock lasts `cfg_div`+1 cycles of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Serial clock half-period minus one, in clk cycles |
| cfg_poll_limit | input | 16 | Extra status polls allowed before timeout |
| req_valid | input | 1 | Host request present, held until ready |
| req_op | input | 2 | 0 read, 1 byte write, 2 sector erase, 3 chip erase |
| req_size | input | 2 | Read size: 0 byte, 1 word, 2/3 doubleword |
| req_addr | input | 24 | Flash byte address |
| req_wdata | input | 8 | Byte to program |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read data, little-endian |
| erase_done | output | 1 | Erase finished, with ready |
| timeout_err | output | 1 | Sticky status-poll timeout |
| bb_req | input | 1 | Software asks for the flash pins |
| bb_grant | output | 1 | Software owns the flash pins |
| bb_cs_n | input | 1 | Software chip select |
| bb_sck | input | 1 | Software serial clock |
| bb_mosi | input | 1 | Software serial data out |
| spi_cs_n | output | 1 | Flash chip select |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Flash data in |
| spi_miso | input | 1 | Flash data out |

## Verification
Reads use random addresses, sizes and clock dividers against a behavioural flash whose contents differ at every address. A wrong byte order, a missing lane or a shifted address therefore gives a different word, and the captured command frame shows whether the address went out unchanged. The write, erase and chip-erase chains are checked frame by frame. The model stays busy for a chosen number of polls, which separates too few polls, too many polls and a missing write-enable. A poll count that never clears checks the timeout path. A request made during software ownership checks that the pins stay with software and that the held request still finishes afterwards.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int unsigned ADDR_W      = 24;
  localparam int unsigned SECTOR_BITS = 12;

  localparam logic [7:0] CMD_READ   = 8'h03;
  localparam logic [7:0] CMD_WREN   = 8'h06;
  localparam logic [7:0] CMD_PROG   = 8'h02;
  localparam logic [7:0] CMD_STAT   = 8'h05;
  localparam logic [7:0] CMD_SERASE = 8'h20;
  localparam logic [7:0] CMD_CERASE = 8'hC7;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_SERASE = 2'd2,
    OP_CERASE = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    FR_WREN, FR_READ, FR_PROG, FR_SERASE, FR_CERASE, FR_POLL
  } frame_e;

  // Number of link bytes in a frame of the given kind.
  function automatic logic [3:0] frame_len(frame_e k, logic [3:0] nrd);
    case (k)
      FR_READ:   return 4'd4 + nrd;
      FR_PROG:   return 4'd5;
      FR_SERASE: return 4'd4;
      FR_POLL:   return 4'd2;
      default:   return 4'd1;
    endcase
  endfunction

  // Byte sent at position idx of a frame.
  function automatic logic [7:0] frame_byte(frame_e k, logic [3:0] idx,
                                            logic [ADDR_W-1:0] a, logic [7:0] wd);
    logic [ADDR_W-1:0] ea;
    logic [7:0]        cmd;
    ea = a;
    case (k)
      FR_WREN:   cmd = CMD_WREN;
      FR_READ:   cmd = CMD_READ;
      FR_PROG:   cmd = CMD_PROG;
      FR_SERASE: begin
        cmd = CMD_SERASE;
        ea  = {a[ADDR_W-1:SECTOR_BITS], {SECTOR_BITS{1'b0}}};
      end
      FR_CERASE: cmd = CMD_CERASE;
      default:   cmd = CMD_STAT;
    endcase
    if (idx == 4'd0) return cmd;
    if (k == FR_WREN || k == FR_CERASE || k == FR_POLL) return 8'h00;
    case (idx)
      4'd1:    return ea[23:16];
      4'd2:    return ea[15:8];
      4'd3:    return ea[7:0];
      4'd4:    return (k == FR_PROG) ? wd : 8'h00;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sfc_spi_byte.sv
module sfc_spi_byte #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [7:0]       tx,
  input  logic             miso,
  output logic             sck,
  output logic             mosi,
  output logic             done,
  output logic [7:0]       rx
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [2:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d, rx_q, rx_d;
  logic             busy_q, busy_d, sck_q, sck_d, done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    rx_d   = rx_q;
    busy_d = busy_q;
    sck_d  = sck_q;
    done_d = 1'b0;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      sh_d   = tx;
      cnt_d  = '0;
      bit_d  = '0;
      sck_d  = 1'b0;
    end else if (busy_q) begin
      if (cnt_q == div) begin
        cnt_d = '0;
        if (!sck_q) begin
          sck_d = 1'b1;
          rx_d  = {rx_q[6:0], miso};
        end else begin
          sck_d = 1'b0;
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            sh_d  = {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      rx_q   <= rx_d;
      busy_q <= busy_d;
      sck_q  <= sck_d;
      done_q <= done_d;
    end
  end

  assign sck  = sck_q;
  assign mosi = sh_q[7];
  assign done = done_q;
  assign rx   = rx_q;

  // R2: mode 0 clock idles low outside a byte
  a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q);
  // R2: output bit holds while the clock is high
  a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    sck_q |-> $stable(sh_q[7]));
endmodule

// File: rtl/sfc_seq.sv
module sfc_seq
  import sfc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [POLL_W-1:0] cfg_poll_limit,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  output logic              erase_done,
  output logic              timeout_err,
  input  logic              bb_req,
  output logic              bb_grant,
  output logic              cs_n,
  output logic              eng_start,
  output logic [7:0]        eng_tx,
  input  logic              eng_done,
  input  logic [7:0]        eng_rx
);
  localparam int unsigned NB = DATA_W / 8;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_SHIFT, ST_GAP, ST_DONE} st_e;

  st_e               st_q, st_d;
  op_e               op_q, op_d;
  frame_e            kind_q, kind_d, last_q, last_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wd_q, wd_d;
  logic [3:0]        nrd_q, nrd_d, idx_q, idx_d, flen;
  logic [POLL_W-1:0] pcnt_q, pcnt_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              cs_q, cs_d, sbusy_q, sbusy_d, tmo_q, tmo_d, grant_q, grant_d;

  assign flen = frame_len(kind_q, nrd_q);

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    kind_d  = kind_q;
    last_d  = last_q;
    addr_d  = addr_q;
    wd_d    = wd_q;
    nrd_d   = nrd_q;
    idx_d   = idx_q;
    pcnt_d  = pcnt_q;
    rdata_d = rdata_q;
    cs_d    = cs_q;
    sbusy_d = sbusy_q;
    tmo_d   = tmo_q;
    grant_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        grant_d = bb_req;
        if (req_valid && !bb_req && !grant_q) begin
          op_d    = op_e'(req_op);
          addr_d  = req_addr;
          wd_d    = req_wdata;
          nrd_d   = (req_size == 2'd0) ? 4'd1 : (req_size == 2'd1) ? 4'd2 : 4'(NB);
          pcnt_d  = '0;
          rdata_d = '0;
          idx_d   = '0;
          kind_d  = (op_e'(req_op) == OP_READ) ? FR_READ : FR_WREN;
          st_d    = ST_START;
        end
      end
      ST_START: begin
        cs_d = 1'b0;
        st_d = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (eng_done) begin
          for (int b = 0; b < NB; b++) begin
            if (kind_q == FR_READ && idx_q == 4'(4 + b)) rdata_d[b*8 +: 8] = eng_rx;
          end
          if (kind_q == FR_POLL && idx_q == 4'd1) sbusy_d = eng_rx[0];
          if (idx_q == flen - 4'd1) begin
            cs_d   = 1'b1;
            idx_d  = '0;
            last_d = kind_q;
            st_d   = ST_GAP;
          end else begin
            idx_d = idx_q + 4'd1;
            st_d  = ST_START;
          end
        end
      end
      ST_GAP: begin
        case (kind_q)
          FR_WREN: begin
            kind_d = (op_q == OP_WRITE)  ? FR_PROG :
                     (op_q == OP_SERASE) ? FR_SERASE : FR_CERASE;
            st_d   = ST_START;
          end
          FR_READ: st_d = ST_DONE;
          FR_POLL: begin
            if (!sbusy_q) begin
              st_d = ST_DONE;
            end else if (pcnt_q == cfg_poll_limit) begin
              tmo_d = 1'b1;
              st_d  = ST_DONE;
            end else begin
              pcnt_d = pcnt_q + 1'b1;
              st_d   = ST_START;
            end
          end
          default: begin
            kind_d = FR_POLL;
            st_d   = ST_START;
          end
        endcase
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_READ;
      kind_q  <= FR_READ;
      last_q  <= FR_POLL;
      addr_q  <= '0;
      wd_q    <= '0;
      nrd_q   <= 4'd1;
      idx_q   <= '0;
      pcnt_q  <= '0;
      rdata_q <= '0;
      cs_q    <= 1'b1;
      sbusy_q <= 1'b0;
      tmo_q   <= 1'b0;
      grant_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      op_q    <= op_d;
      kind_q  <= kind_d;
      last_q  <= last_d;
      addr_q  <= addr_d;
      wd_q    <= wd_d;
      nrd_q   <= nrd_d;
      idx_q   <= idx_d;
      pcnt_q  <= pcnt_d;
      rdata_q <= rdata_d;
      cs_q    <= cs_d;
      sbusy_q <= sbusy_d;
      tmo_q   <= tmo_d;
      grant_q <= grant_d;
    end
  end

  assign eng_start   = (st_q == ST_START);
  assign eng_tx      = frame_byte(kind_q, idx_q, addr_q, wd_q);
  assign cs_n        = cs_q;
  assign req_ready   = (st_q == ST_DONE);
  assign req_rdata   = rdata_q;
  assign erase_done  = (st_q == ST_DONE) && (op_q == OP_SERASE || op_q == OP_CERASE);
  assign timeout_err = tmo_q;
  assign bb_grant    = grant_q;

  // R1: chip select released whenever no request is in flight
  a_r1_cs_high_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> cs_q);
  // R4: completion is a single-cycle pulse
  a_r4_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  // R5: every program or erase frame directly follows a write-enable frame
  a_r5_wren_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_START && idx_q == 4'd0 &&
     (kind_q == FR_PROG || kind_q == FR_SERASE || kind_q == FR_CERASE))
    |-> (last_q == FR_WREN));
  // R8: timeout flag is sticky
  a_r8_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_q |=> tmo_q);
  // R9: no host sequence runs while software owns the pins
  a_r9_grant_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> (st_q == ST_IDLE));
endmodule

// File: rtl/sfc_mmio_ctrl.sv
module sfc_mmio_ctrl
  import sfc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned POLL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [POLL_W-1:0] cfg_poll_limit,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic [DATA_W-1:0] req_rdata,
  output logic              erase_done,
  output logic              timeout_err,
  input  logic              bb_req,
  output logic              bb_grant,
  input  logic              bb_cs_n,
  input  logic              bb_sck,
  input  logic              bb_mosi,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [1:0] rsync_q;
  logic       rst_int_n;
  logic       eng_start, eng_done, seq_cs_n, eng_sck, eng_mosi;
  logic [7:0] eng_tx, eng_rx;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  sfc_seq #(.DATA_W(DATA_W), .POLL_W(POLL_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .cfg_poll_limit(cfg_poll_limit),
    .req_valid(req_valid), .req_op(req_op), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .erase_done(erase_done), .timeout_err(timeout_err),
    .bb_req(bb_req), .bb_grant(bb_grant), .cs_n(seq_cs_n),
    .eng_start(eng_start), .eng_tx(eng_tx), .eng_done(eng_done), .eng_rx(eng_rx)
  );

  sfc_spi_byte #(.DIV_W(DIV_W)) u_byte (
    .clk(clk), .rst_n(rst_int_n), .div(cfg_div), .start(eng_start),
    .tx(eng_tx), .miso(spi_miso), .sck(eng_sck), .mosi(eng_mosi),
    .done(eng_done), .rx(eng_rx)
  );

  assign spi_cs_n = bb_grant ? bb_cs_n : seq_cs_n;
  assign spi_sck  = bb_grant ? bb_sck  : eng_sck;
  assign spi_mosi = bb_grant ? bb_mosi : eng_mosi;
endmodule

// File: tb/test_sfc_mmio_ctrl.sv
module test_sfc_mmio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  cfg_div = 8'd0;
  logic [15:0] cfg_poll_limit = 16'd50;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0, req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, erase_done, timeout_err, bb_grant;
  logic [31:0] req_rdata;
  logic        bb_req = 1'b0, bb_cs_n = 1'b1, bb_sck = 1'b0, bb_mosi = 1'b0;
  logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

  sfc_mmio_ctrl i_sfc_mmio_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_poll_limit(cfg_poll_limit),
    .req_valid(req_valid), .req_op(req_op), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .erase_done(erase_done), .timeout_err(timeout_err),
    .bb_req(bb_req), .bb_grant(bb_grant), .bb_cs_n(bb_cs_n), .bb_sck(bb_sck),
    .bb_mosi(bb_mosi), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc_total = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural flash ----------------
  logic [7:0] mem [0:255];
  logic [7:0] fr  [0:15];
  logic [2:0] bitc = '0;
  logic [3:0] bytec = '0;
  logic [7:0] sh = '0;
  int         busy_left = 0, busy_polls = 0;
  logic [7:0] log_cmd  [0:255];
  logic [23:0] log_adr [0:255];
  logic [7:0] log_dat  [0:255];
  logic [3:0] log_len  [0:255];
  int         log_n = 0;
  logic [7:0] ob;

  function automatic logic [7:0] init_byte(int a);
    return 8'((a * 37) ^ 8'h5A ^ (a >> 3));
  endfunction

  always @(negedge spi_cs_n) begin bitc = '0; bytec = '0; end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bitc = bitc + 3'd1;
    if (bitc == 3'd0) begin
      fr[bytec] = sh;
      if (bytec != 4'd15) bytec = bytec + 4'd1;
    end
  end

  always @(posedge spi_cs_n) begin
    log_cmd[log_n % 256] = fr[0];
    log_adr[log_n % 256] = {fr[1], fr[2], fr[3]};
    log_dat[log_n % 256] = fr[4];
    log_len[log_n % 256] = bytec;
    log_n++;
    if (fr[0] == 8'h02) begin mem[fr[3]] = fr[4]; busy_left = busy_polls; end
    else if (fr[0] == 8'h20 || fr[0] == 8'hC7) busy_left = busy_polls;
    else if (fr[0] == 8'h05 && busy_left > 0) busy_left--;
  end

  always_comb begin
    ob = 8'h00;
    if (fr[0] == 8'h03 && bytec >= 4'd4) ob = mem[8'(fr[3] + 8'(bytec - 4'd4))];
    else if (fr[0] == 8'h05 && bytec >= 4'd1) ob = {7'd0, busy_left != 0};
    spi_miso = spi_cs_n ? 1'b0 : ob[3'd7 - bitc];
  end

  // serial clock high-phase width monitor (R10)
  int hi_run = 0, last_hi = 0;
  always @(negedge clk) begin
    if (spi_sck) hi_run++;
    else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
  end

  // watchdog
  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 190000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc_total);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic do_op(input logic [1:0] op, input logic [1:0] sz, input logic [23:0] a,
                       input logic [7:0] wd, output logic [31:0] rd, output bit ed);
    int cyc = 0;
    @(negedge clk);
    req_op = op; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready && cyc < 40000) begin @(negedge clk); cyc++; end
    chk(cyc < 40000, "R4 completion", cyc, 40000);
    rd = req_rdata; ed = erase_done;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R4 ready one cycle", {31'd0, req_ready}, 0);
  endtask

  function automatic logic [31:0] exp_read(logic [23:0] a, logic [1:0] sz);
    logic [31:0] v = '0;
    int n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    for (int k = 0; k < n; k++) v[k*8 +: 8] = mem[8'(a[7:0] + 8'(k))];
    return v;
  endfunction

  initial begin
    logic [31:0] rd, ex;
    bit ed;
    int base;
    for (int i = 0; i < 256; i++) mem[i] = init_byte(i);
    for (int i = 0; i < 16; i++) fr[i] = 8'h00;
    void'($urandom(32'h0051F1A5));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1, "R1 cs_n", {31'd0, spi_cs_n}, 1);
    chk(spi_sck == 1'b0, "R1 sck", {31'd0, spi_sck}, 0);
    chk(!req_ready && !erase_done, "R1 ready", {30'd0, req_ready, erase_done}, 0);
    chk(!bb_grant && !timeout_err, "R1 grant/tmo", {30'd0, bb_grant, timeout_err}, 0);
    log_n = 0;

    // random reads: R2, R3, R4, R10
    for (int t = 0; t < 24; t++) begin
      logic [23:0] a = 24'($urandom);
      logic [1:0] sz = 2'($urandom_range(0, 3));
      cfg_div = 8'($urandom_range(0, 3));
      base = log_n;
      ex = exp_read(a, sz);
      do_op(2'd0, sz, a, 8'h00, rd, ed);
      chk(rd == ex, "R3 read data", rd, ex);
      chk(log_n == base + 1 && log_cmd[base % 256] == 8'h03, "R2 read cmd",
          {24'd0, log_cmd[base % 256]}, 32'h03);
      chk(log_adr[base % 256] == a, "R2 read addr", {8'd0, log_adr[base % 256]}, {8'd0, a});
      chk(last_hi == int'(cfg_div) + 1, "R10 sck half period", last_hi, int'(cfg_div) + 1);
    end

    // directed read wrapping the model index, size 3 treated as four bytes (R3)
    cfg_div = 8'd1;
    ex = exp_read(24'h0000FE, 2'd3);
    do_op(2'd0, 2'd3, 24'h0000FE, 8'h00, rd, ed);
    chk(rd == ex, "R3 size3 dword", rd, ex);
    ex = exp_read(24'h000010, 2'd0);
    do_op(2'd0, 2'd0, 24'h000010, 8'h00, rd, ed);
    chk(rd[31:8] == 24'd0 && rd == ex, "R3 byte upper lanes zero", rd, ex);

    // byte write (R5)
    busy_polls = 2;
    base = log_n;
    do_op(2'd1, 2'd2, 24'h0A0B33, 8'hC4, rd, ed);
    chk(log_n == base + 5, "R5 frame count", log_n - base, 5);
    chk(log_cmd[base % 256] == 8'h06 && log_len[base % 256] == 4'd1, "R5 wren frame",
        {24'd0, log_cmd[base % 256]}, 32'h06);
    chk(log_cmd[(base+1) % 256] == 8'h02 && log_len[(base+1) % 256] == 4'd5, "R5 program cmd",
        {24'd0, log_cmd[(base+1) % 256]}, 32'h02);
    chk(log_adr[(base+1) % 256] == 24'h0A0B33 && log_dat[(base+1) % 256] == 8'hC4, "R5 program addr/data",
        {log_adr[(base+1) % 256], log_dat[(base+1) % 256]}, 32'h0A0B33C4);
    chk(log_cmd[(base+2) % 256] == 8'h05 && log_cmd[(base+4) % 256] == 8'h05 &&
        log_len[(base+4) % 256] == 4'd2, "R5 status polls", {24'd0, log_cmd[(base+4) % 256]}, 32'h05);
    chk(!ed, "R5 no erase_done on write", {31'd0, ed}, 0);
    do_op(2'd0, 2'd0, 24'h0A0B33, 8'h00, rd, ed);
    chk(rd == 32'h000000C4, "R5 readback", rd, 32'hC4);

    // sector erase (R6)
    busy_polls = 1;
    base = log_n;
    do_op(2'd2, 2'd0, 24'h12ABCD, 8'h00, rd, ed);
    chk(log_n == base + 4, "R6 frame count", log_n - base, 4);
    chk(log_cmd[base % 256] == 8'h06, "R6 wren", {24'd0, log_cmd[base % 256]}, 32'h06);
    chk(log_cmd[(base+1) % 256] == 8'h20 && log_len[(base+1) % 256] == 4'd4, "R6 erase cmd",
        {24'd0, log_cmd[(base+1) % 256]}, 32'h20);
    chk(log_adr[(base+1) % 256] == 24'h12A000, "R6 sector aligned addr",
        {8'd0, log_adr[(base+1) % 256]}, 32'h12A000);
    chk(ed, "R6 erase_done", {31'd0, ed}, 1);

    // chip erase (R7)
    busy_polls = 0;
    base = log_n;
    do_op(2'd3, 2'd0, 24'h000000, 8'h00, rd, ed);
    chk(log_n == base + 3, "R7 frame count", log_n - base, 3);
    chk(log_cmd[(base+1) % 256] == 8'hC7 && log_len[(base+1) % 256] == 4'd1, "R7 chip erase cmd",
        {24'd0, log_cmd[(base+1) % 256]}, 32'hC7);
    chk(ed, "R7 erase_done", {31'd0, ed}, 1);
    chk(!timeout_err, "R8 no timeout yet", {31'd0, timeout_err}, 0);

    // poll timeout (R8)
    cfg_poll_limit = 16'd3;
    busy_polls = 100;
    base = log_n;
    do_op(2'd2, 2'd0, 24'h004000, 8'h00, rd, ed);
    chk(log_n == base + 6, "R8 poll count at limit", log_n - base, 6);
    chk(timeout_err, "R8 timeout set", {31'd0, timeout_err}, 1);
    busy_left = 0; busy_polls = 0;
    do_op(2'd0, 2'd0, 24'h000020, 8'h00, rd, ed);
    chk(timeout_err, "R8 timeout sticky", {31'd0, timeout_err}, 1);

    // bit-bang ownership (R9)
    @(negedge clk);
    bb_req = 1'b1; bb_sck = 1'b1; bb_mosi = 1'b1; bb_cs_n = 1'b1;
    @(negedge clk);
    chk(bb_grant, "R9 grant next cycle", {31'd0, bb_grant}, 1);
    chk(spi_sck && spi_mosi && spi_cs_n, "R9 pins follow software",
        {29'd0, spi_sck, spi_mosi, spi_cs_n}, 7);
    base = log_n;
    req_op = 2'd0; req_size = 2'd1; req_addr = 24'h000040; req_valid = 1'b1;
    begin
      bit seen = 1'b0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (req_ready) seen = 1'b1; end
      chk(!seen && log_n == base && spi_sck, "R9 request held off", {31'd0, seen}, 0);
    end
    bb_sck = 1'b0; bb_mosi = 1'b0; bb_req = 1'b0;
    ex = exp_read(24'h000040, 2'd1);
    begin
      int cyc = 0;
      while (!req_ready && cyc < 40000) begin @(negedge clk); cyc++; end
      rd = req_rdata;
      req_valid = 1'b0;
    end
    chk(rd == ex && log_n == base + 1, "R9 held request completes", rd, ex);
    chk(!bb_grant, "R9 grant released", {31'd0, bb_grant}, 0);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule